// File: doc/BRIEF.md
# Segment Address Translator

This block turns a 32-bit virtual address into a 32-bit physical address by variable-size segmentation. The top eight address bits pick one of 256 segment descriptors kept in on-chip registers. The low 24 bits are an offset into that segment. The physical address is the segment's 32-bit base plus the offset, computed as a full add. The offset is also checked against the segment's 24-bit length.

Software loads descriptors through a one-cycle write port. Each descriptor holds a base, a length, a present flag and separate read and write permission bits. A lookup presents an address and an access type. One cycle later it returns a valid strobe with either a physical address or a fault code. The fault codes cover an absent segment, an out-of-range offset and a permission violation.

Top module: `seg_xlat`

## Requirements
- R1: The segment index is virtual address bits 31..24. The offset is bits 23..0.
- R2: On success, the physical address is base + offset, a 32-bit add that wraps modulo 2^32.
- R3: Fault code 1 (absent) is returned when the descriptor's present flag is clear. Reset clears the present flag of every descriptor.
- R4: Fault code 2 (bounds) is returned when the offset is greater than or equal to the segment length. A length of 0 rejects every offset.
- R5: Fault code 3 (protection) is returned for a write to a segment without write permission, or a read from a segment without read permission.
- R6: When several faults apply, absent takes priority over bounds, and bounds takes priority over protection.
- R7: A request accepted on a clock edge produces `rsp_valid_o` high for exactly the following cycle. Without a request, `rsp_valid_o` is low and the fault code and address outputs are 0.
- R8: Whenever the fault code is non-zero, the physical address output is 0. Fault code 0 means success.
- R9: A descriptor write takes effect at the clock edge that accepts it. A lookup accepted at that same edge sees the old descriptor. Lookups accepted from the next edge onward see the new descriptor.
- R10: A segment of length 258 at base 10000 maps offsets 0 and 257 to addresses 10000 and 10257, and faults at offset 258.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Descriptor write enable |
| wr_idx_i | input | 8 | Descriptor index to write |
| wr_base_i | input | 32 | Segment physical base |
| wr_len_i | input | 24 | Segment length in bytes |
| wr_present_i | input | 1 | Segment present flag |
| wr_rd_ok_i | input | 1 | Read permission |
| wr_wr_ok_i | input | 1 | Write permission |
| req_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Access type: 1 write, 0 read |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_fault_o | output | 2 | 0 ok, 1 absent, 2 bounds, 3 protection |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |

## Verification
Several properties are checked by assertions on every cycle:
- the one-cycle request-to-response timing;
- a zero address on any fault;
- quiet outputs when there is no request;
- the landing of every descriptor write in the table on the next cycle.

The bench's scenarios cover what the assertions cannot:
- fault priority;
- address wrap-around;
- the bounds edge at length and length minus one;
- a zero-length segment;
- the reset state of the present flags;
- the old-versus-new outcome when a write and a lookup share an edge.

A behavioural model compares every response on every clock.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int unsigned VA_W  = 32;
  localparam int unsigned PA_W  = 32;
  localparam int unsigned OFF_W = 24;
  localparam int unsigned IDX_W = VA_W - OFF_W;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ABSENT  = 2'd1,
    FLT_BOUNDS  = 2'd2,
    FLT_PROTECT = 2'd3
  } fault_e;

  typedef struct packed {
    logic [PA_W-1:0]  base;
    logic [OFF_W-1:0] len;
    logic             rd_ok;
    logic             wr_ok;
  } seg_desc_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlat_pkg::*;
#(
  parameter int unsigned N_SEG = 256,
  localparam int unsigned SEL_W = $clog2(N_SEG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_idx_i,
  input  seg_desc_t        wr_desc_i,
  input  logic             wr_present_i,
  input  logic [SEL_W-1:0] rd_idx_i,
  output seg_desc_t        rd_desc_o,
  output logic             rd_present_o
);
  seg_desc_t        desc_q [N_SEG];
  logic [N_SEG-1:0] present_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) desc_q[wr_idx_i] <= wr_desc_i;
  end

  // presence is the only state that must be defined after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) present_q <= '0;
    else if (wr_en_i) present_q[wr_idx_i] <= wr_present_i;
  end

  assign rd_desc_o    = desc_q[rd_idx_i];
  assign rd_present_o = present_q[rd_idx_i];

  assert_write_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (desc_q[$past(wr_idx_i)] == $past(wr_desc_i))
                && (present_q[$past(wr_idx_i)] == $past(wr_present_i)));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
(
  input  seg_desc_t        desc_i,
  input  logic             present_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             write_i,
  output fault_e           fault_o,
  output logic [PA_W-1:0]  paddr_o
);
  logic out_of_range;
  logic no_perm;

  assign out_of_range = (off_i >= desc_i.len);
  assign no_perm      = write_i ? !desc_i.wr_ok : !desc_i.rd_ok;

  always_comb begin
    if (!present_i)        fault_o = FLT_ABSENT;
    else if (out_of_range) fault_o = FLT_BOUNDS;
    else if (no_perm)      fault_o = FLT_PROTECT;
    else                   fault_o = FLT_NONE;
  end

  assign paddr_o = desc_i.base + {{(PA_W-OFF_W){1'b0}}, off_i};
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int unsigned N_SEG = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  wr_idx_i,
  input  logic [31:0] wr_base_i,
  input  logic [23:0] wr_len_i,
  input  logic        wr_present_i,
  input  logic        wr_rd_ok_i,
  input  logic        wr_wr_ok_i,
  input  logic        req_i,
  input  logic [31:0] req_vaddr_i,
  input  logic        req_write_i,
  output logic        rsp_valid_o,
  output logic [1:0]  rsp_fault_o,
  output logic [31:0] rsp_paddr_o
);
  localparam int unsigned SEL_W = $clog2(N_SEG);

  seg_desc_t        wr_desc, rd_desc;
  logic             rd_present;
  logic [SEL_W-1:0] seg_idx;
  logic [OFF_W-1:0] seg_off;
  fault_e           fault_d;
  logic [PA_W-1:0]  paddr_d;

  assign seg_idx = req_vaddr_i[VA_W-1 -: SEL_W];
  assign seg_off = req_vaddr_i[OFF_W-1:0];
  assign wr_desc = '{base: wr_base_i, len: wr_len_i, rd_ok: wr_rd_ok_i, wr_ok: wr_wr_ok_i};

  seg_desc_table #(.N_SEG(N_SEG)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i[SEL_W-1:0]),
    .wr_desc_i    (wr_desc),
    .wr_present_i (wr_present_i),
    .rd_idx_i     (seg_idx),
    .rd_desc_o    (rd_desc),
    .rd_present_o (rd_present)
  );

  seg_check u_check (
    .desc_i    (rd_desc),
    .present_i (rd_present),
    .off_i     (seg_off),
    .write_i   (req_write_i),
    .fault_o   (fault_d),
    .paddr_o   (paddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 2'd0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_i;
      rsp_fault_o <= req_i ? fault_d : FLT_NONE;
      rsp_paddr_o <= (req_i && fault_d == FLT_NONE) ? paddr_d : '0;
    end
  end

  assert_rsp_follows_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  assert_rsp_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rsp_valid_o && rsp_fault_o == 2'd0 && rsp_paddr_o == '0));
  assert_fault_no_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o != 2'd0) |-> (rsp_paddr_o == '0 && rsp_valid_o));
  assert_absent_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !rd_present) |=> (rsp_fault_o == 2'd1));
endmodule

// File: tb/sim_seg_xlat.sv
module sim_seg_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_idx = '0;
  logic [31:0] wr_base = '0;
  logic [23:0] wr_len = '0;
  logic        wr_present = 1'b0, wr_rd_ok = 1'b0, wr_wr_ok = 1'b0;
  logic        req = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_paddr;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // behavioural model
  logic [31:0] m_base [256];
  int          m_len  [256];
  bit          m_pres [256];
  bit          m_rd   [256];
  bit          m_wr   [256];

  always #10 clk = ~clk;

  seg_xlat u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_base_i(wr_base), .wr_len_i(wr_len),
    .wr_present_i(wr_present), .wr_rd_ok_i(wr_rd_ok), .wr_wr_ok_i(wr_wr_ok),
    .req_i(req), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  task automatic check(string tag, logic v, logic [1:0] f, logic [31:0] a,
                       logic ev, logic [1:0] ef, logic [31:0] ea);
    n_tests++;
    if (v !== ev || f !== ef || a !== ea) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b f=%0d a=%h expected v=%0b f=%0d a=%h",
               tag, v, f, a, ev, ef, ea);
    end
  endtask

  // one cycle: optional write and optional lookup, driven at negedge
  task automatic step(string tag, bit do_wr, int widx, logic [31:0] wb, int wl,
                      bit wp, bit wrd, bit wwr, bit do_rq, logic [31:0] va, bit wt);
    logic [1:0]  ef;
    logic [31:0] ea;
    int          s;
    int          off;
    wr_en = do_wr; wr_idx = widx[7:0]; wr_base = wb; wr_len = wl[23:0];
    wr_present = wp; wr_rd_ok = wrd; wr_wr_ok = wwr;
    req = do_rq; req_vaddr = va; req_write = wt;
    @(posedge clk);
    s = int'(va[31:24]); off = int'(va[23:0]);
    ef = 2'd0; ea = '0;
    if (do_rq) begin
      if (!m_pres[s]) ef = 2'd1;
      else if (off >= m_len[s]) ef = 2'd2;
      else if (wt ? !m_wr[s] : !m_rd[s]) ef = 2'd3;
      else ea = m_base[s] + 32'(off);
    end
    if (do_wr) begin
      m_base[widx] = wb; m_len[widx] = wl; m_pres[widx] = wp;
      m_rd[widx] = wrd; m_wr[widx] = wwr;
    end
    @(negedge clk);
    wr_en = 1'b0; req = 1'b0;
    check(tag, rsp_valid, rsp_fault, rsp_paddr, do_rq, ef, ea);
  endtask

  task automatic lookup(string tag, logic [31:0] va, bit wt);
    step(tag, 0, 0, '0, 0, 0, 0, 0, 1, va, wt);
  endtask

  task automatic load(string tag, int idx, logic [31:0] b, int l, bit p, bit r, bit w);
    step(tag, 1, idx, b, l, p, r, w, 0, '0, 0);
  endtask

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < 256; i++) begin
      m_base[i] = '0; m_len[i] = 0; m_pres[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R7 reset", rsp_valid, rsp_fault, rsp_paddr, 1'b0, 2'd0, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    lookup("R3 absent after reset", 32'h0500_0010, 0);
    lookup("R3 absent seg0 after reset", 32'h0000_0000, 1);
    // write and lookup at the same edge: old descriptor seen
    step("R9 same-edge old", 1, 1, 32'd10000, 258, 1, 1, 1, 1, 32'h0100_0000, 0);
    lookup("R9 visible next", 32'h0100_0000, 0);
    lookup("R10 last byte", 32'h0100_0101, 1);
    lookup("R10 R4 first out", 32'h0100_0102, 0);
    load("R2 load wrap seg", 2, 32'hFFFF_FF00, 32'h1000, 1, 1, 0);
    lookup("R2 wrap add", 32'h0200_0200, 0);
    lookup("R5 write denied", 32'h0200_0010, 1);
    load("R5 load write-only", 6, 32'h0008_0000, 16, 1, 0, 1);
    lookup("R5 read denied", 32'h0600_0004, 0);
    lookup("R5 write allowed", 32'h0600_0004, 1);
    load("R6 load small seg", 4, 32'h0000_4000, 4, 1, 0, 0);
    lookup("R6 bounds over protect", 32'h0400_000A, 1);
    lookup("R6 protect in range", 32'h0400_0003, 1);
    lookup("R6 absent over bounds", 32'h03FF_FFFF, 1);
    load("R4 load zero len", 255, 32'h1234_0000, 0, 1, 1, 1);
    lookup("R4 zero length", 32'hFF00_0000, 0);
    load("R1 load top seg", 254, 32'h8000_0000, 24'hFFFFFF, 1, 1, 1);
    lookup("R1 top index", 32'hFEFF_FFFE, 1);
    step("R7 idle", 0, 0, '0, 0, 0, 0, 0, 0, 32'h0100_0000, 0);
    load("R3 mark absent", 1, 32'd10000, 258, 0, 1, 1);
    lookup("R3 absent after clear", 32'h0100_0000, 0);
    lcg = 32'h1357_9bdf;
    for (int k = 0; k < 60; k++) begin
      logic [7:0] segs [6];
      segs = '{8'd1, 8'd2, 8'd4, 8'd6, 8'd254, 8'd255};
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[3:0] == 4'd0)
        load("R9 random load", int'(segs[lcg[7:5] % 6]), lcg ^ 32'h5a5a_0000,
             int'(lcg[15:8]), lcg[16], lcg[17], lcg[18]);
      else
        step("R1 random", lcg[4], int'(segs[lcg[10:8] % 6]), lcg, int'(lcg[27:20]),
             lcg[11], 1, lcg[12], 1,
             {segs[lcg[7:5] % 6], 16'h0, lcg[31:24]}, lcg[13]);
    end
    finish_run();
  end
endmodule